// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block turns the two phase signals and the index signal of an incremental encoder into a position count. The phase and index inputs arrive already synchronized to the block clock. Each step of one phase moves the count by one, up or down. The direction comes from which phase changes first. Two resolutions are available. In the half-resolution setting only transitions of phase A count, and phase B supplies only the direction. In the full-resolution setting every transition of either phase counts.

The count returns to zero in one of two ways. In the index-reset modes the index mark, when enabled, clears the count, and any other wrap happens at the natural 16-bit boundary. In these modes a limit check watches the count. Counting up past the programmed maximum, or counting down past zero, sets a sticky error flag and may raise an error interrupt. In the maximum-count modes the count wraps between zero and the programmed maximum. Every detected index mark raises a one-cycle interrupt. The current direction is always visible as a status bit, and it is driven onto a pin only when the pin is enabled. Configuration comes from plain register-style ports.

Top module: `qenc_position_counter`

## Requirements
- R1: After reset: pos_count is 0, dir_status is 0, err_flag is 0, and irq_index and irq_error are both 0.
- R2: Mode encodings are 3'b100 (x2, index reset), 3'b101 (x2, max reset), 3'b110 (x4, index reset) and 3'b111 (x4, max reset). In the x4 modes, every single-phase transition along the forward sequence AB = 00,10,11,01,00 (A leads B) adds one to pos_count. The count changes on the clock edge that first samples the new input level. dir_status then reads 1.
- R3: In the x4 modes, transitions along the reverse sequence AB = 00,01,11,10,00 subtract one from pos_count, and dir_status reads 0.
- R4: In the x2 modes, only transitions of phase A change pos_count. A transition of phase B alone leaves the count unchanged but still updates dir_status.
- R5: An index event is the rising of the condition (idx high while pha and phb are both low). In any of the four valid modes, each event produces irq_index high for exactly one cycle. The idx input raised while pha is high produces no event.
- R6: In the index-reset modes, an index event with cfg_idx_clear_en = 1 clears pos_count to 0. With cfg_idx_clear_en = 0, the count is kept, and irq_index is still raised.
- R7: In the maximum-count modes, counting up from cfg_max_count gives 0, and counting down from 0 gives cfg_max_count. irq_error is never raised in these modes.
- R8: In the index-reset modes, counting up from cfg_max_count (the count reaching max+1), or counting down from 0 (the count reaching 0xFFFF), sets err_flag. The count continues to the natural value, and irq_error pulses for one cycle.
- R9: err_flag stays set until err_clear is pulsed. cfg_err_irq_mask = 1 stops irq_error but still lets err_flag set.
- R10: dir_pin equals dir_status when cfg_dir_out_en = 1, and it is 0 when cfg_dir_out_en = 0.
- R11: With cfg_mode[2] = 0, pos_count holds its value and neither interrupt is raised.
- R12: A sample in which both phases change at once is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pha | input | 1 | Encoder phase A, synchronized |
| phb | input | 1 | Encoder phase B, synchronized |
| idx | input | 1 | Encoder index mark, synchronized |
| cfg_mode | input | 3 | Operating mode select |
| cfg_idx_clear_en | input | 1 | Index event clears count (index-reset modes) |
| cfg_err_irq_mask | input | 1 | Masks the error interrupt |
| cfg_dir_out_en | input | 1 | Drives direction onto dir_pin |
| cfg_max_count | input | 16 | Maximum count / limit value |
| err_clear | input | 1 | Write pulse that clears err_flag |
| pos_count | output | 16 | Position count |
| dir_status | output | 1 | Last decoded direction, 1 = forward |
| dir_pin | output | 1 | Gated direction output |
| err_flag | output | 1 | Sticky count-limit error |
| irq_index | output | 1 | One-cycle pulse per index event |
| irq_error | output | 1 | One-cycle pulse per count-limit error |

## Verification
The hardest situation to reach is a limit error in the index-reset modes, in either direction. An upward error needs the count to sit exactly at the programmed maximum when a forward step arrives. A downward error needs the count at zero when a reverse step arrives. The bench first clears the count with an index mark, then drives a counted number of forward steps against a small maximum. It then walks back down through zero with the error interrupt masked. This shows the flag set, its stickiness, its clearing, and the count running on past both limits.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

  localparam int unsigned MODE_W = 3;

  // mode field decode: bit2 = enabled, bit1 = full resolution, bit0 = max-count wrap
  function automatic logic mode_active(input logic [MODE_W-1:0] m);
    return m[2];
  endfunction

  function automatic logic mode_full_res(input logic [MODE_W-1:0] m);
    return m[2] & m[1];
  endfunction

  function automatic logic mode_index_reset(input logic [MODE_W-1:0] m);
    return m[2] & ~m[0];
  endfunction

  function automatic logic mode_max_wrap(input logic [MODE_W-1:0] m);
    return m[2] & m[0];
  endfunction

  // direction of a single-phase step given previous B and present A
  function automatic logic step_is_forward(input logic prev_b, input logic cur_a);
    return cur_a ^ prev_b;
  endfunction

endpackage

// File: rtl/qenc_edge_decode.sv
module qenc_edge_decode
  import qenc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pha,
  input  logic phb,
  input  logic active,
  input  logic full_res,
  output logic count_pulse,
  output logic count_up,
  output logic dir_q
);

  logic a_q, b_q;
  logic a_edge, b_edge, single_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= 1'b0;
      b_q <= 1'b0;
    end else begin
      a_q <= pha;
      b_q <= phb;
    end
  end

  assign a_edge      = pha ^ a_q;
  assign b_edge      = phb ^ b_q;
  assign single_edge = a_edge ^ b_edge;
  assign count_up    = step_is_forward(b_q, pha);

  always_comb begin
    count_pulse = 1'b0;
    if (active) begin
      if (full_res) count_pulse = single_edge;
      else          count_pulse = a_edge & ~b_edge;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           dir_q <= 1'b0;
    else if (single_edge) dir_q <= count_up;
  end

endmodule

// File: rtl/qenc_index_detect.sv
module qenc_index_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic pha,
  input  logic phb,
  input  logic idx,
  output logic index_event
);

  logic qual, qual_q;

  assign qual = idx & ~pha & ~phb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) qual_q <= 1'b0;
    else        qual_q <= qual;
  end

  assign index_event = qual & ~qual_q;

endmodule

// File: rtl/qenc_pos_counter.sv
module qenc_pos_counter #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          idx_mode,
  input  logic          max_mode,
  input  logic          count_pulse,
  input  logic          count_up,
  input  logic          index_event,
  input  logic          clear_en,
  input  logic [CW-1:0] max_count,
  input  logic          err_clear,
  input  logic          err_mask,
  output logic          index_clear,
  output logic          err_event,
  output logic [CW-1:0] pos_count,
  output logic          err_flag,
  output logic          irq_index,
  output logic          irq_error
);

  localparam int unsigned XW = CW + 1;

  function automatic logic [CW-1:0] step_natural(input logic [CW-1:0] c, input logic up);
    return up ? c + 1'b1 : c - 1'b1;
  endfunction

  function automatic logic [CW-1:0] step_bounded(input logic [CW-1:0] c, input logic up,
                                                 input logic [CW-1:0] mx);
    if (up) return (c == mx) ? '0 : c + 1'b1;
    else    return (c == '0) ? mx : c - 1'b1;
  endfunction

  // limit hit: next value equals max+1 going up, or all-ones going down
  function automatic logic hits_limit(input logic [CW-1:0] c, input logic up,
                                      input logic [CW-1:0] mx);
    logic [XW-1:0] nxt;
    if (up) begin
      nxt = {1'b0, c} + XW'(1);
      return nxt == ({1'b0, mx} + XW'(1));
    end else begin
      return c == '0;
    end
  endfunction

  logic [CW-1:0] cnt_next;

  assign index_clear = active & idx_mode & clear_en & index_event;
  assign err_event   = active & idx_mode & count_pulse & ~index_clear
                     & hits_limit(pos_count, count_up, max_count);

  always_comb begin
    cnt_next = pos_count;
    if (index_clear)
      cnt_next = '0;
    else if (count_pulse) begin
      if (max_mode) cnt_next = step_bounded(pos_count, count_up, max_count);
      else          cnt_next = step_natural(pos_count, count_up);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_count <= '0;
      err_flag  <= 1'b0;
      irq_index <= 1'b0;
      irq_error <= 1'b0;
    end else begin
      pos_count <= cnt_next;
      if (err_event)      err_flag <= 1'b1;
      else if (err_clear) err_flag <= 1'b0;
      irq_index <= active & index_event;
      irq_error <= err_event & ~err_mask;
    end
  end

endmodule

// File: rtl/qenc_position_counter.sv
module qenc_position_counter
  import qenc_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pha,
  input  logic          phb,
  input  logic          idx,
  input  logic [2:0]    cfg_mode,
  input  logic          cfg_idx_clear_en,
  input  logic          cfg_err_irq_mask,
  input  logic          cfg_dir_out_en,
  input  logic [CW-1:0] cfg_max_count,
  input  logic          err_clear,
  output logic [CW-1:0] pos_count,
  output logic          dir_status,
  output logic          dir_pin,
  output logic          err_flag,
  output logic          irq_index,
  output logic          irq_error
);

  logic active, full_res, idx_mode, max_mode;
  logic count_pulse, count_up, index_event, index_clear, err_event;

  assign active   = mode_active(cfg_mode);
  assign full_res = mode_full_res(cfg_mode);
  assign idx_mode = mode_index_reset(cfg_mode);
  assign max_mode = mode_max_wrap(cfg_mode);

  qenc_edge_decode u_edge (
    .clk(clk), .rst_n(rst_n), .pha(pha), .phb(phb),
    .active(active), .full_res(full_res),
    .count_pulse(count_pulse), .count_up(count_up), .dir_q(dir_status)
  );

  qenc_index_detect u_index (
    .clk(clk), .rst_n(rst_n), .pha(pha), .phb(phb), .idx(idx),
    .index_event(index_event)
  );

  qenc_pos_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .active(active), .idx_mode(idx_mode),
    .max_mode(max_mode), .count_pulse(count_pulse), .count_up(count_up),
    .index_event(index_event), .clear_en(cfg_idx_clear_en),
    .max_count(cfg_max_count), .err_clear(err_clear), .err_mask(cfg_err_irq_mask),
    .index_clear(index_clear), .err_event(err_event),
    .pos_count(pos_count), .err_flag(err_flag),
    .irq_index(irq_index), .irq_error(irq_error)
  );

  assign dir_pin = cfg_dir_out_en & dir_status;

endmodule

// File: rtl/qenc_position_counter_checker.sv
module qenc_position_counter_checker #(
  parameter int unsigned CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    cfg_mode,
  input logic          cfg_err_irq_mask,
  input logic [CW-1:0] cfg_max_count,
  input logic          err_clear,
  input logic [CW-1:0] pos_count,
  input logic          err_flag,
  input logic          irq_index,
  input logic          irq_error,
  input logic          count_pulse,
  input logic          count_up,
  input logic          index_clear
);

  assert_hold_when_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_mode[2] |=> (pos_count == $past(pos_count)) && !irq_index && !irq_error);

  assert_up_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode[2] && !cfg_mode[0] && count_pulse && count_up && !index_clear)
      |=> pos_count == CW'($past(pos_count) + 1'b1));

  assert_down_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode[2] && !cfg_mode[0] && count_pulse && !count_up && !index_clear)
      |=> pos_count == CW'($past(pos_count) - 1'b1));

  assert_index_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_index |=> !irq_index);

  assert_index_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    index_clear |=> pos_count == '0);

  assert_max_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode[2] && cfg_mode[0] && pos_count <= cfg_max_count)
      |=> pos_count <= $past(cfg_max_count));

  assert_no_err_in_max_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode[2] && cfg_mode[0]) |=> !irq_error);

  assert_err_irq_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_error |-> err_flag);

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !err_clear) |=> err_flag);

  assert_err_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_error |-> !$past(cfg_err_irq_mask));

endmodule

bind qenc_position_counter qenc_position_counter_checker #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_err_irq_mask(cfg_err_irq_mask),
  .cfg_max_count(cfg_max_count), .err_clear(err_clear), .pos_count(pos_count),
  .err_flag(err_flag), .irq_index(irq_index), .irq_error(irq_error),
  .count_pulse(count_pulse), .count_up(count_up), .index_clear(index_clear)
);

// File: tb/qenc_position_counter_test.sv
`timescale 1ns/1ps
module qenc_position_counter_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pha = 1'b0, phb = 1'b0, idx = 1'b0;
  logic [2:0]  cfg_mode = 3'b000;
  logic        cfg_idx_clear_en = 1'b0, cfg_err_irq_mask = 1'b0, cfg_dir_out_en = 1'b0;
  logic [15:0] cfg_max_count = 16'hFFFF;
  logic        err_clear = 1'b0;
  logic [15:0] pos_count;
  logic        dir_status, dir_pin, err_flag, irq_index, irq_error;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  qenc_position_counter uut (
    .clk(clk), .rst_n(rst_n), .pha(pha), .phb(phb), .idx(idx),
    .cfg_mode(cfg_mode), .cfg_idx_clear_en(cfg_idx_clear_en),
    .cfg_err_irq_mask(cfg_err_irq_mask), .cfg_dir_out_en(cfg_dir_out_en),
    .cfg_max_count(cfg_max_count), .err_clear(err_clear),
    .pos_count(pos_count), .dir_status(dir_status), .dir_pin(dir_pin),
    .err_flag(err_flag), .irq_index(irq_index), .irq_error(irq_error)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // apply one input sample, then look just after the capturing edge
  task automatic apply(input logic a, input logic b, input logic i);
    @(negedge clk);
    pha = a; phb = b; idx = i;
    @(posedge clk);
    #1;
  endtask

  task automatic fwd();  // AB 00->10->11->01->00
    apply(~phb, pha, 1'b0);
  endtask

  task automatic rev();  // AB 00->01->11->10->00
    apply(phb, ~pha, 1'b0);
  endtask

  task automatic idle();
    apply(pha, phb, 1'b0);
  endtask

  task automatic t_reset();
    chk("R1 count", pos_count, 0);
    chk("R1 dir", dir_status, 0);
    chk("R1 err", err_flag, 0);
    chk("R1 irqs", {irq_index, irq_error}, 0);
  endtask

  task automatic t_x4_forward();
    cfg_mode = 3'b110;
    for (int k = 1; k <= 4; k++) begin
      fwd();
      chk("R2 x4 up count", pos_count, k);
    end
    chk("R2 dir forward", dir_status, 1);
  endtask

  task automatic t_x4_reverse();
    for (int k = 3; k >= 0; k--) begin
      rev();
      chk("R3 x4 down count", pos_count, k);
    end
    chk("R3 dir reverse", dir_status, 0);
  endtask

  task automatic t_both_change();
    apply(1'b1, 1'b1, 1'b0);
    chk("R12 double change ignored", pos_count, 0);
    apply(1'b0, 1'b0, 1'b0);
    chk("R12 double change back ignored", pos_count, 0);
  endtask

  task automatic t_x2();
    cfg_mode = 3'b100;
    fwd(); chk("R4 A rise counts", pos_count, 1);
    fwd(); chk("R4 B rise no count", pos_count, 1);
    fwd(); chk("R4 A fall counts", pos_count, 2);
    fwd(); chk("R4 B fall no count", pos_count, 2);
    chk("R4 dir fwd", dir_status, 1);
    rev(); chk("R4 B edge sets dir", dir_status, 0);
    chk("R4 B edge count held", pos_count, 2);
    fwd(); chk("R4 B edge dir back", dir_status, 1);
  endtask

  task automatic t_index();
    cfg_mode = 3'b110; cfg_idx_clear_en = 1'b0;
    apply(1'b0, 1'b0, 1'b1);
    chk("R5 irq_index pulse", irq_index, 1);
    chk("R6 no clear when disabled", pos_count, 2);
    idle(); chk("R5 irq_index one cycle", irq_index, 0);
    fwd();
    apply(1'b1, 1'b0, 1'b1);
    chk("R5 idx with A high no event", irq_index, 0);
    apply(1'b0, 1'b0, 1'b0);
    cfg_idx_clear_en = 1'b1;
    apply(1'b0, 1'b0, 1'b1);
    chk("R6 index clears", pos_count, 0);
    chk("R5 irq on clear", irq_index, 1);
    idle();
    cfg_mode = 3'b111;
    apply(1'b0, 1'b0, 1'b1);
    chk("R5 irq in max mode", irq_index, 1);
    idle();
  endtask

  task automatic t_max_wrap();
    cfg_mode = 3'b111; cfg_max_count = 16'd5;
    for (int k = 1; k <= 5; k++) fwd();
    chk("R7 reaches max", pos_count, 5);
    fwd(); chk("R7 up wraps to 0", pos_count, 0);
    rev(); chk("R7 down loads max", pos_count, 5);
    chk("R7 no error in max mode", err_flag, 0);
    for (int k = 1; k <= 5; k++) rev();
    chk("R7 back to 0", pos_count, 0);
    while (pha | phb) rev();
  endtask

  task automatic t_error();
    cfg_mode = 3'b110; cfg_max_count = 16'd3; cfg_idx_clear_en = 1'b1;
    apply(1'b0, 1'b0, 1'b1); idle();
    chk("R6 cleared before error test", pos_count, 0);
    for (int k = 1; k <= 3; k++) fwd();
    chk("R8 at max no error", err_flag, 0);
    fwd();
    chk("R8 count passes max", pos_count, 4);
    chk("R8 err set up", err_flag, 1);
    chk("R8 irq_error pulse", irq_error, 1);
    idle();
    chk("R8 irq_error one cycle", irq_error, 0);
    chk("R9 err sticky", err_flag, 1);
    @(negedge clk); err_clear = 1'b1;
    @(posedge clk); #1;
    @(negedge clk); err_clear = 1'b0;
    chk("R9 err cleared", err_flag, 0);
    cfg_err_irq_mask = 1'b1;
    for (int k = 1; k <= 4; k++) rev();
    chk("R8 down to 0", pos_count, 0);
    chk("R8 no err passing max downward", err_flag, 0);
    rev();
    chk("R8 underflow value", pos_count, 16'hFFFF);
    chk("R8 err set down", err_flag, 1);
    chk("R9 masked irq_error", irq_error, 0);
    cfg_err_irq_mask = 1'b0;
    fwd();
    chk("R8 counts on after error", pos_count, 0);
  endtask

  task automatic t_dir_pin();
    cfg_dir_out_en = 1'b0;
    fwd();
    chk("R10 pin off", dir_pin, 0);
    cfg_dir_out_en = 1'b1; #1;
    chk("R10 pin on forward", dir_pin, 1);
    rev();
    chk("R10 pin follows reverse", dir_pin, 0);
  endtask

  task automatic t_off();
    logic [15:0] held;
    held = pos_count;
    cfg_mode = 3'b000;
    fwd(); fwd();
    chk("R11 count held", pos_count, held);
    while (pha | phb) fwd();
    apply(1'b0, 1'b0, 1'b1);
    chk("R11 no irq_index", irq_index, 0);
    chk("R11 count held after idx", pos_count, held);
    idle();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    t_reset();
    t_x4_forward();
    t_x4_reverse();
    t_both_change();
    t_x2();
    t_index();
    t_max_wrap();
    t_error();
    t_dir_pin();
    t_off();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule